// File: doc/BRIEF.md
# Zero-Overhead Repeat Loop Sequencer

This block owns the program counter of a packet-issuing core and works out the counter's value after each issued packet. The counter counts 32-bit instruction words, so one step forward is one word. Without a loop the counter steps by one word, or takes a branch target when the packet reports a taken branch. The core can also arm a hardware repeat block by giving its first word, its last word and an iteration count. When a packet issues from the last word of an armed block, the sequencer uses up one iteration and goes back to the first word. No branch instruction is needed and no cycle is lost.

When the final iteration is used up, the block disarms itself and execution falls through to the word after the last word. An armed block's end check wins over any branch reported by the packet at that address. A setup command with a zero count loads the block's registers but does not arm it. On reset the counter takes the value on a reset-vector input and every loop register clears.

Top module: `loop_pc_ctrl`

## Requirements
- R1: While `rst_ni` is low, `pc_o` equals `rst_vec_i` and `loop_active_o` is 0.
- R2: An issued packet with no taken branch, when the loop is not armed at `pc_o`, moves `pc_o` to `pc_o + 1` (one instruction word).
- R3: An issued packet with `br_taken_i` high, when the loop is not armed at `pc_o`, moves `pc_o` to `br_target_i`.
- R4: With `issue_i` low, `pc_o` keeps its value and `next_pc_o` equals `pc_o`, even if `br_taken_i` is high.
- R5: `setup_i` with a non-zero count loads the loop's first word, last word and count, and sets `loop_active_o` on the next cycle.
- R6: `setup_i` with a count of zero leaves `loop_active_o` at 0, and a later packet at that last word does not loop.
- R7: An issued packet at the last word of an armed loop whose remaining count is above 1 moves `pc_o` to the first word and lowers the count by one. The loop stays armed.
- R8: An issued packet at the last word of an armed loop whose remaining count is 1 clears `loop_active_o` and moves `pc_o` to `pc_o + 1`.
- R9: At the last word of an armed loop, `br_taken_i` and `br_target_i` have no effect on the next counter value.
- R10: The counter wraps from all ones to zero on a sequential step.
- R11: When `setup_i` and an issued packet at an armed last word fall in the same cycle, the next `pc_o` follows the old loop registers, and the loop registers take the new setup values.
- R12: `next_pc_o` shows, before the clock edge, the value `pc_o` takes at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rst_vec_i | input | 16 | Counter value loaded on reset |
| issue_i | input | 1 | A packet issues in this cycle |
| br_taken_i | input | 1 | The issuing packet takes a branch |
| br_target_i | input | 16 | Branch target word address |
| setup_i | input | 1 | Arm command for the repeat block |
| setup_start_i | input | 16 | First word of the repeat block |
| setup_end_i | input | 16 | Last word of the repeat block |
| setup_cnt_i | input | 16 | Number of iterations |
| pc_o | output | 16 | Current instruction word address |
| next_pc_o | output | 16 | Value pc_o takes at the next edge |
| loop_active_o | output | 1 | Repeat block is armed |

## Verification
Two cases can share a cycle. In the first, a packet reports a taken branch while it issues from an armed last word. In the second, a new setup command arrives in the same cycle as a loop-end decrement. The bench drives a branch at the last word both on a looping iteration and on the final one, and expects the start word or the fall-through word instead of the target. It also drives a setup together with an issue at a last word whose count is 1. It expects the fall-through address from the old registers, and then checks that the next trip through the new last word jumps to the new first word and exits after the new count.

// File: rtl/loop_pc_pkg.sv
package loop_pc_pkg;
  typedef enum logic [1:0] {
    SEL_HOLD   = 2'd0,
    SEL_SEQ    = 2'd1,
    SEL_TARGET = 2'd2,
    SEL_LOOP   = 2'd3
  } pc_sel_e;
endpackage

// File: rtl/loop_pc_regs.sv
module loop_pc_regs #(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             setup_i,
  input  logic [PC_W-1:0]  setup_start_i,
  input  logic [PC_W-1:0]  setup_end_i,
  input  logic [CNT_W-1:0] setup_cnt_i,
  input  logic             step_i,
  output logic [PC_W-1:0]  start_o,
  output logic [PC_W-1:0]  end_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             active_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [PC_W-1:0]  start_q, end_q;
  logic [CNT_W-1:0] cnt_q;
  logic             active_q;

  // setup wins over a same-cycle loop-end decrement
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q  <= '0;
      end_q    <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (setup_i) begin
      start_q  <= setup_start_i;
      end_q    <= setup_end_i;
      cnt_q    <= setup_cnt_i;
      active_q <= |setup_cnt_i;
    end else if (step_i) begin
      cnt_q <= cnt_q - CNT_ONE;
      if (cnt_q == CNT_ONE) active_q <= 1'b0;
    end
  end

  assign start_o  = start_q;
  assign end_o    = end_q;
  assign cnt_o    = cnt_q;
  assign active_o = active_q;
  assign last_o   = (cnt_q == CNT_ONE);
endmodule

// File: rtl/loop_pc_sel.sv
module loop_pc_sel
  import loop_pc_pkg::*;
#(
  parameter int unsigned PC_W = 16
) (
  input  logic            issue_i,
  input  logic            at_end_i,
  input  logic            last_i,
  input  logic            br_taken_i,
  input  logic [PC_W-1:0] br_target_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic [PC_W-1:0] start_i,
  output logic [PC_W-1:0] next_pc_o
);
  localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);

  pc_sel_e sel;

  // loop end outranks a reported branch
  always_comb begin
    if (!issue_i)                 sel = SEL_HOLD;
    else if (at_end_i && !last_i) sel = SEL_LOOP;
    else if (at_end_i)            sel = SEL_SEQ;
    else if (br_taken_i)          sel = SEL_TARGET;
    else                          sel = SEL_SEQ;
  end

  always_comb begin
    unique case (sel)
      SEL_HOLD:   next_pc_o = pc_i;
      SEL_SEQ:    next_pc_o = pc_i + PC_ONE;
      SEL_TARGET: next_pc_o = br_target_i;
      SEL_LOOP:   next_pc_o = start_i;
      default:    next_pc_o = pc_i;
    endcase
  end
endmodule

// File: rtl/loop_pc_ctrl.sv
module loop_pc_ctrl #(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PC_W-1:0]  rst_vec_i,
  input  logic             issue_i,
  input  logic             br_taken_i,
  input  logic [PC_W-1:0]  br_target_i,
  input  logic             setup_i,
  input  logic [PC_W-1:0]  setup_start_i,
  input  logic [PC_W-1:0]  setup_end_i,
  input  logic [CNT_W-1:0] setup_cnt_i,
  output logic [PC_W-1:0]  pc_o,
  output logic [PC_W-1:0]  next_pc_o,
  output logic             loop_active_o
);
  logic [PC_W-1:0]  pc_q, pc_d;
  logic [PC_W-1:0]  start_q, end_q;
  logic [CNT_W-1:0] cnt_q;
  logic             active_q, last_q, at_end, loop_step;

  assign at_end    = active_q && (pc_q == end_q);
  assign loop_step = issue_i && at_end;

  loop_pc_regs #(.PC_W(PC_W), .CNT_W(CNT_W)) i_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .setup_i       (setup_i),
    .setup_start_i (setup_start_i),
    .setup_end_i   (setup_end_i),
    .setup_cnt_i   (setup_cnt_i),
    .step_i        (loop_step),
    .start_o       (start_q),
    .end_o         (end_q),
    .cnt_o         (cnt_q),
    .active_o      (active_q),
    .last_o        (last_q)
  );

  loop_pc_sel #(.PC_W(PC_W)) i_sel (
    .issue_i     (issue_i),
    .at_end_i    (at_end),
    .last_i      (last_q),
    .br_taken_i  (br_taken_i),
    .br_target_i (br_target_i),
    .pc_i        (pc_q),
    .start_i     (start_q),
    .next_pc_o   (pc_d)
  );

  // reset vector is sampled while reset is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= rst_vec_i;
    else         pc_q <= pc_d;
  end

  assign pc_o          = pc_q;
  assign next_pc_o     = pc_d;
  assign loop_active_o = active_q;
endmodule

// File: rtl/loop_pc_ctrl_chk.sv
module loop_pc_ctrl_chk #(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             issue_i,
  input logic             br_taken_i,
  input logic [PC_W-1:0]  br_target_i,
  input logic             setup_i,
  input logic [CNT_W-1:0] setup_cnt_i,
  input logic [PC_W-1:0]  pc_o,
  input logic [PC_W-1:0]  next_pc_o,
  input logic             loop_active_o,
  input logic [PC_W-1:0]  start_q,
  input logic [PC_W-1:0]  end_q,
  input logic [CNT_W-1:0] cnt_q
);
  logic at_end;
  assign at_end = loop_active_o && (pc_o == end_q);

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_i |=> pc_o == $past(pc_o));

  p_seq_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i && !br_taken_i && !at_end |=> pc_o == $past(pc_o) + 1'b1);

  p_branch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i && br_taken_i && !at_end |=> pc_o == $past(br_target_i));

  p_loop_back_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i && at_end && cnt_q != CNT_W'(1) |=> pc_o == $past(start_q));

  p_count_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i && at_end && !setup_i && cnt_q != CNT_W'(1)
    |=> loop_active_o && cnt_q == $past(cnt_q) - 1'b1);

  p_exit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i && at_end && !setup_i && cnt_q == CNT_W'(1)
    |=> !loop_active_o && pc_o == $past(pc_o) + 1'b1);

  p_setup_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_i && setup_cnt_i != '0 |=> loop_active_o && cnt_q == $past(setup_cnt_i));

  p_setup_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_i && setup_cnt_i == '0 |=> !loop_active_o);

  p_next_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> pc_o == $past(next_pc_o));
endmodule

bind loop_pc_ctrl loop_pc_ctrl_chk #(.PC_W(PC_W), .CNT_W(CNT_W)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .issue_i       (issue_i),
  .br_taken_i    (br_taken_i),
  .br_target_i   (br_target_i),
  .setup_i       (setup_i),
  .setup_cnt_i   (setup_cnt_i),
  .pc_o          (pc_o),
  .next_pc_o     (next_pc_o),
  .loop_active_o (loop_active_o),
  .start_q       (start_q),
  .end_q         (end_q),
  .cnt_q         (cnt_q)
);

// File: tb/test_loop_pc_ctrl.sv
`timescale 1ns/1ps
module test_loop_pc_ctrl;
  typedef struct packed {
    logic [63:0] tag;
    logic        setup;
    logic [15:0] s_start;
    logic [15:0] s_end;
    logic [15:0] s_cnt;
    logic        issue;
    logic        br;
    logic [15:0] tgt;
    logic [15:0] exp_pc;
    logic        exp_act;
  } vec_t;

  localparam int NV = 18;
  localparam logic [15:0] VEC = 16'h0100;

  // each row: one cycle of stimulus, then pc_o / loop_active_o after the edge
  localparam vec_t TBL [NV] = '{
    '{"R5 R2", 1'b1, 16'h0102, 16'h0104, 16'd2, 1'b1, 1'b0, 16'h0000, 16'h0101, 1'b1},
    '{"R2",    1'b0, 16'h0000, 16'h0000, 16'd0, 1'b1, 1'b0, 16'h0000, 16'h0102, 1'b1},
    '{"R2",    1'b0, 16'h0000, 16'h0000, 16'd0, 1'b1, 1'b0, 16'h0000, 16'h0103, 1'b1},
    '{"R2",    1'b0, 16'h0000, 16'h0000, 16'd0, 1'b1, 1'b0, 16'h0000, 16'h0104, 1'b1},
    '{"R7",    1'b0, 16'h0000, 16'h0000, 16'd0, 1'b1, 1'b0, 16'h0000, 16'h0102, 1'b1},
    '{"R2",    1'b0, 16'h0000, 16'h0000, 16'd0, 1'b1, 1'b0, 16'h0000, 16'h0103, 1'b1},
    '{"R3",    1'b0, 16'h0000, 16'h0000, 16'd0, 1'b1, 1'b1, 16'h0104, 16'h0104, 1'b1},
    '{"R8 R9", 1'b0, 16'h0000, 16'h0000, 16'd0, 1'b1, 1'b1, 16'h0200, 16'h0105, 1'b0},
    '{"R3",    1'b0, 16'h0000, 16'h0000, 16'd0, 1'b1, 1'b1, 16'h0104, 16'h0104, 1'b0},
    '{"R2",    1'b0, 16'h0000, 16'h0000, 16'd0, 1'b1, 1'b0, 16'h0000, 16'h0105, 1'b0},
    '{"R4",    1'b0, 16'h0000, 16'h0000, 16'd0, 1'b0, 1'b1, 16'h0300, 16'h0105, 1'b0},
    '{"R6",    1'b1, 16'h0106, 16'h0106, 16'd0, 1'b1, 1'b0, 16'h0000, 16'h0106, 1'b0},
    '{"R6",    1'b0, 16'h0000, 16'h0000, 16'd0, 1'b1, 1'b0, 16'h0000, 16'h0107, 1'b0},
    '{"R5 R4", 1'b1, 16'h0108, 16'h0108, 16'd3, 1'b0, 1'b0, 16'h0000, 16'h0107, 1'b1},
    '{"R2",    1'b0, 16'h0000, 16'h0000, 16'd0, 1'b1, 1'b0, 16'h0000, 16'h0108, 1'b1},
    '{"R7 R9", 1'b0, 16'h0000, 16'h0000, 16'd0, 1'b1, 1'b1, 16'h0050, 16'h0108, 1'b1},
    '{"R7",    1'b0, 16'h0000, 16'h0000, 16'd0, 1'b1, 1'b0, 16'h0000, 16'h0108, 1'b1},
    '{"R8",    1'b0, 16'h0000, 16'h0000, 16'd0, 1'b1, 1'b0, 16'h0000, 16'h0109, 1'b0}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        issue_i = 1'b0, br_taken_i = 1'b0, setup_i = 1'b0;
  logic [15:0] br_target_i = '0, setup_start_i = '0, setup_end_i = '0, setup_cnt_i = '0;
  logic [15:0] pc_o, next_pc_o;
  logic        loop_active_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  loop_pc_ctrl i_loop_pc_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rst_vec_i     (VEC),
    .issue_i       (issue_i),
    .br_taken_i    (br_taken_i),
    .br_target_i   (br_target_i),
    .setup_i       (setup_i),
    .setup_start_i (setup_start_i),
    .setup_end_i   (setup_end_i),
    .setup_cnt_i   (setup_cnt_i),
    .pc_o          (pc_o),
    .next_pc_o     (next_pc_o),
    .loop_active_o (loop_active_o)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input logic su, input logic [15:0] ss, input logic [15:0] se,
                       input logic [15:0] sc, input logic iss, input logic br,
                       input logic [15:0] tg);
    @(negedge clk_i);
    setup_i = su; setup_start_i = ss; setup_end_i = se; setup_cnt_i = sc;
    issue_i = iss; br_taken_i = br; br_target_i = tg;
  endtask

  task automatic edge_wait();
    @(posedge clk_i);
    #2;
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got hung expected finished");
      report();
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #2;
    chk("R1 pc", pc_o, VEC);
    chk("R1 active", {15'd0, loop_active_o}, 16'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk("R4 next idle", next_pc_o, VEC);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].setup, TBL[i].s_start, TBL[i].s_end, TBL[i].s_cnt,
            TBL[i].issue, TBL[i].br, TBL[i].tgt);
      edge_wait();
      chk($sformatf("%s row%0d pc", TBL[i].tag, i), pc_o, TBL[i].exp_pc);
      chk($sformatf("%s row%0d active", TBL[i].tag, i), {15'd0, loop_active_o},
          {15'd0, TBL[i].exp_act});
    end

    // R10: wrap from all ones
    drive(1'b0, 0, 0, 0, 1'b1, 1'b1, 16'hFFFF);
    edge_wait();
    chk("R3 to top", pc_o, 16'hFFFF);
    drive(1'b0, 0, 0, 0, 1'b1, 1'b0, 0);
    edge_wait();
    chk("R10 wrap", pc_o, 16'h0000);

    // R11: setup colliding with loop exit
    drive(1'b0, 0, 0, 0, 1'b1, 1'b1, 16'h0020);
    edge_wait();
    chk("R3 jump", pc_o, 16'h0020);
    drive(1'b1, 16'h0020, 16'h0021, 16'd1, 1'b0, 1'b0, 0);
    edge_wait();
    chk("R5 armed", {15'd0, loop_active_o}, 16'd1);
    drive(1'b0, 0, 0, 0, 1'b1, 1'b0, 0);
    edge_wait();
    chk("R2 to end", pc_o, 16'h0021);
    drive(1'b1, 16'h0040, 16'h0022, 16'd2, 1'b1, 1'b0, 0);
    #1;
    chk("R12 R11 next", next_pc_o, 16'h0022);
    edge_wait();
    chk("R11 pc old regs", pc_o, 16'h0022);
    chk("R11 rearmed", {15'd0, loop_active_o}, 16'd1);
    drive(1'b0, 0, 0, 0, 1'b1, 1'b0, 0);
    #1;
    chk("R12 loop next", next_pc_o, 16'h0040);
    edge_wait();
    chk("R11 new start", pc_o, 16'h0040);
    drive(1'b0, 0, 0, 0, 1'b1, 1'b1, 16'h0022);
    edge_wait();
    chk("R3 back to end", pc_o, 16'h0022);
    drive(1'b0, 0, 0, 0, 1'b1, 1'b0, 0);
    edge_wait();
    chk("R11 new count exit pc", pc_o, 16'h0023);
    chk("R11 new count exit active", {15'd0, loop_active_o}, 16'd0);

    // R1: reset in mid-loop
    drive(1'b1, 16'h0030, 16'h0031, 16'd5, 1'b0, 1'b0, 0);
    edge_wait();
    chk("R5 armed again", {15'd0, loop_active_o}, 16'd1);
    drive(1'b0, 0, 0, 0, 1'b0, 1'b0, 0);
    rst_ni = 1'b0;
    #1;
    chk("R1 async pc", pc_o, VEC);
    chk("R1 async active", {15'd0, loop_active_o}, 16'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    drive(1'b0, 0, 0, 0, 1'b1, 1'b0, 0);
    edge_wait();
    chk("R1 restart", pc_o, VEC + 16'd1);

    done = 1'b1;
    report();
  end
endmodule